// File: doc/BRIEF.md
# Radix-2 Butterfly Index Sequencer

This block walks the complete in-place radix-2 butterfly schedule of an N-point transform, where N is a power of two from 2 up to 2^MAX_LOG2N (64 by default). Each step it presents three indices: the lower element of the pair, the upper element of the pair, and the twiddle coefficient that scales the upper element. The arithmetic datapath takes these indices and performs the butterfly. This block produces only the indices.

A run begins with a start pulse. The pulse captures the transform size, the bit-reversed numbering option and the stepping mode. In free-running mode the sequencer emits one triple per clock. In single-step mode it holds the current triple until the consumer pulses the step input. The block reports the total number of steps in the run and marks the final triple. After the final triple is consumed, it returns to idle.

Top module: `fft_bfly_sched`

## Requirements
- R1: After reset, busy, valid and last are low and total_steps is 0.
- R2: A start sampled while idle, with 1 <= log2n <= MAX_LOG2N, makes busy and valid high in the next cycle. The first triple shown is lo_idx=0, hi_idx=1, coef_idx=0.
- R3: Triples follow three nested loops. The outer loop takes span S = 2, 4, ... N. The middle loop takes group base G = 0, S, 2S, ... below N. The inner loop takes j from G to G+S/2-1. Each triple has lo_idx = j and hi_idx = j + S/2.
- R4: coef_idx is (j - G) * (N / S). It starts at 0 in each group and grows by N/S per inner step.
- R5: When rev_order was high at start, lo_idx and hi_idx are shown bit-reversed over log2n bits, so index bit b appears at bit log2n-1-b. coef_idx is never reversed.
- R6: In free-running mode (step_mode low at start), a new triple is presented on every clock while busy.
- R7: In single-step mode (step_mode high at start), a triple stays on the outputs with valid high until a cycle in which step is high. The next triple appears one cycle later.
- R8: total_steps equals log2n * N/2 for the most recently accepted start, for example 12 for N=8. It is valid from the cycle after that start.
- R9: last is high exactly while the final triple of the run is shown. Consuming that triple leaves busy and valid low in the next cycle.
- R10: A start while busy is ignored, whatever log2n then holds. A start with log2n of 0 or above MAX_LOG2N is also ignored and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| step_mode | input | 1 | Captured at start: 1 = advance on step pulses, 0 = advance every cycle |
| step | input | 1 | Consume the current triple in single-step mode |
| log2n | input | $clog2(MAX_LOG2N+1) | Transform size exponent, captured at start |
| rev_order | input | 1 | Captured at start: present data indices bit-reversed |
| busy | output | 1 | A run is in progress |
| valid | output | 1 | lo_idx, hi_idx, coef_idx hold a current triple |
| lo_idx | output | MAX_LOG2N | Lower element index of the butterfly |
| hi_idx | output | MAX_LOG2N | Upper element index of the butterfly |
| coef_idx | output | MAX_LOG2N | Twiddle coefficient index |
| last | output | 1 | Current triple is the final one of the run |
| total_steps | output | MAX_LOG2N+$clog2(MAX_LOG2N+1) | Number of triples in the run |

## Verification
The start pulse is registered once, so the first triple and total_steps appear at the clock edge after start is sampled. Each later triple appears at the edge after the one that consumed its predecessor, and the idle state appears at the edge after the last triple is consumed. The bench drives inputs on the falling edge and compares the outputs on the following falling edge with a queue built from the nested loops. In single-step mode it also holds step low for a cycle and confirms the triple is unchanged before issuing the step.

// File: rtl/fft_sched_pkg.sv
package fft_sched_pkg;

   // Upper bound accepted for the size exponent parameter.
   localparam int unsigned LOG2N_CEIL = 16;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/fft_idx_rev.sv
// Reverses the low NB bits of an index, where NB is a run-time count.
module fft_idx_rev #(
   parameter int unsigned W  = 6,
   parameter int unsigned LW = 3
) (
   input  logic [W-1:0]  val,
   input  logic [LW-1:0] nbits,
   output logic [W-1:0]  rev
);

   logic [W-1:0] full_rev;

   // Mirror all W bits, then drop the W-nbits that were zero-padding.
   for (genvar b = 0; b < W; b++) begin : g_mirror
      assign full_rev[b] = val[W-1-b];
   end

   always_comb begin
      rev = full_rev >> (LW'(W) - nbits);
   end

endmodule

// File: rtl/fft_loop_ctr.sv
// Span / group / offset counters for the in-place radix-2 schedule.
module fft_loop_ctr #(
   parameter int unsigned IW = 6,
   parameter int unsigned LW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          adv,
   input  logic [LW-1:0] cfg_l,
   output logic [IW-1:0] lo_raw,
   output logic [IW-1:0] hi_raw,
   output logic [IW-1:0] coef,
   output logic          final_o
);

   localparam int unsigned XW = IW + 1;

   logic [LW-1:0] stage_q;
   logic [IW-1:0] grp_q, off_q, kk_q;
   logic [XW-1:0] half_w, size_w, n_w, stride_w, grp_next_w;
   logic          off_end, grp_end, stage_end;

   always_comb begin
      half_w     = XW'(1) << stage_q;
      size_w     = half_w << 1;
      n_w        = XW'(1) << cfg_l;
      stride_w   = n_w >> (stage_q + LW'(1));
      grp_next_w = {1'b0, grp_q} + size_w;
      off_end    = ({1'b0, off_q} == (half_w - XW'(1)));
      grp_end    = (grp_next_w == n_w);
      stage_end  = (stage_q == (cfg_l - LW'(1)));
      final_o    = off_end & grp_end & stage_end;
      lo_raw     = grp_q + off_q;
      hi_raw     = lo_raw + half_w[IW-1:0];
      coef       = kk_q;
   end

   always_ff @(posedge clk) begin
      if (rst || load) begin
         stage_q <= '0;
         grp_q   <= '0;
         off_q   <= '0;
         kk_q    <= '0;
      end else if (adv && !final_o) begin
         if (off_end) begin
            off_q <= '0;
            kk_q  <= '0;
            if (grp_end) begin
               grp_q   <= '0;
               stage_q <= stage_q + LW'(1);
            end else begin
               grp_q <= grp_next_w[IW-1:0];
            end
         end else begin
            off_q <= off_q + IW'(1);
            kk_q  <= kk_q + stride_w[IW-1:0];
         end
      end
   end

endmodule

// File: rtl/fft_bfly_sched.sv
module fft_bfly_sched
   import fft_sched_pkg::*;
#(
   parameter int unsigned MAX_LOG2N = 6,
   parameter bit          BITREV_EN = 1'b1,
   localparam int unsigned LW = $clog2(MAX_LOG2N + 1),
   localparam int unsigned TW = MAX_LOG2N + LW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic                 step_mode,
   input  logic                 step,
   input  logic [LW-1:0]        log2n,
   input  logic                 rev_order,
   output logic                 busy,
   output logic                 valid,
   output logic [MAX_LOG2N-1:0] lo_idx,
   output logic [MAX_LOG2N-1:0] hi_idx,
   output logic [MAX_LOG2N-1:0] coef_idx,
   output logic                 last,
   output logic [TW-1:0]        total_steps
);

   localparam int unsigned IW = MAX_LOG2N;

   if (MAX_LOG2N < 1 || MAX_LOG2N > LOG2N_CEIL) begin : g_bad_param
      $error("fft_bfly_sched: MAX_LOG2N out of supported range");
   end

   seq_state_e    state_q;
   logic [LW-1:0] cfg_l;
   logic          cfg_rev, mode_q;
   logic          accept, adv, final_w;
   logic [IW-1:0] lo_raw, hi_raw, coef_raw;
   logic [IW:0]   n_w;

   assign accept = start && (state_q == SEQ_IDLE) &&
                   (log2n != '0) && (log2n <= LW'(MAX_LOG2N));
   assign adv    = (state_q == SEQ_RUN) && (!mode_q || step);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         cfg_l   <= '0;
         cfg_rev <= 1'b0;
         mode_q  <= 1'b0;
      end else if (accept) begin
         state_q <= SEQ_RUN;
         cfg_l   <= log2n;
         cfg_rev <= rev_order;
         mode_q  <= step_mode;
      end else if (adv && final_w) begin
         state_q <= SEQ_IDLE;
      end
   end

   fft_loop_ctr #(.IW(IW), .LW(LW)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .adv     (adv),
      .cfg_l   (cfg_l),
      .lo_raw  (lo_raw),
      .hi_raw  (hi_raw),
      .coef    (coef_raw),
      .final_o (final_w)
   );

   if (BITREV_EN) begin : g_rev
      logic [IW-1:0] lo_rev, hi_rev;
      fft_idx_rev #(.W(IW), .LW(LW)) u_rev_lo (
         .val(lo_raw), .nbits(cfg_l), .rev(lo_rev));
      fft_idx_rev #(.W(IW), .LW(LW)) u_rev_hi (
         .val(hi_raw), .nbits(cfg_l), .rev(hi_rev));
      assign lo_idx = cfg_rev ? lo_rev : lo_raw;
      assign hi_idx = cfg_rev ? hi_rev : hi_raw;
   end else begin : g_norev
      assign lo_idx = lo_raw;
      assign hi_idx = hi_raw;
   end

   assign n_w         = (IW + 1)'(1) << cfg_l;
   assign total_steps = TW'(n_w >> 1) * TW'(cfg_l);
   assign coef_idx    = coef_raw;
   assign busy        = (state_q == SEQ_RUN);
   assign valid       = busy;
   assign last        = busy && final_w;

endmodule

// File: rtl/fft_sched_chk.sv
module fft_sched_chk #(
   parameter int unsigned MAX_LOG2N = 6,
   localparam int unsigned LW = $clog2(MAX_LOG2N + 1),
   localparam int unsigned TW = MAX_LOG2N + LW
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 step,
   input logic                 busy,
   input logic                 valid,
   input logic [MAX_LOG2N-1:0] lo_idx,
   input logic [MAX_LOG2N-1:0] hi_idx,
   input logic [MAX_LOG2N-1:0] coef_idx,
   input logic                 last,
   input logic [TW-1:0]        total_steps,
   input logic                 rev_q,
   input logic                 mode_q
);

   a_r9_last_with_valid: assert property (@(posedge clk) disable iff (rst)
      last |-> valid);

   a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
      (last && (!mode_q || step)) |=> (!busy && !valid));

   a_r3_hi_above_lo: assert property (@(posedge clk) disable iff (rst)
      (valid && !rev_q) |-> (hi_idx > lo_idx));

   a_r4_coef_bounded: assert property (@(posedge clk) disable iff (rst)
      valid |-> ({{LW{1'b0}}, coef_idx} < total_steps));

   a_r6_free_advances: assert property (@(posedge clk) disable iff (rst)
      (busy && !mode_q && !last) |=> (valid && !($stable(lo_idx) && $stable(hi_idx))));

   a_r7_hold_without_step: assert property (@(posedge clk) disable iff (rst)
      (busy && mode_q && !step) |=>
         (valid && $stable(lo_idx) && $stable(hi_idx) && $stable(coef_idx)));

   a_r10_run_not_restarted: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> (busy && $stable(total_steps)));

endmodule

bind fft_bfly_sched fft_sched_chk #(.MAX_LOG2N(MAX_LOG2N)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .step        (step),
   .busy        (busy),
   .valid       (valid),
   .lo_idx      (lo_idx),
   .hi_idx      (hi_idx),
   .coef_idx    (coef_idx),
   .last        (last),
   .total_steps (total_steps),
   .rev_q       (cfg_rev),
   .mode_q      (mode_q)
);

// File: tb/tb_fft_bfly_sched.sv
module tb_fft_bfly_sched;

   localparam int MAXL = 6;
   localparam int LW   = $clog2(MAXL + 1);
   localparam int TW   = MAXL + LW;

   logic clk = 1'b0;
   logic rst, start, step_mode, step, rev_order;
   logic [LW-1:0] log2n;
   logic busy, valid, last;
   logic [MAXL-1:0] lo_idx, hi_idx, coef_idx;
   logic [TW-1:0] total_steps;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fft_bfly_sched #(.MAX_LOG2N(MAXL)) dut (
      .clk(clk), .rst(rst), .start(start), .step_mode(step_mode), .step(step),
      .log2n(log2n), .rev_order(rev_order), .busy(busy), .valid(valid),
      .lo_idx(lo_idx), .hi_idx(hi_idx), .coef_idx(coef_idx), .last(last),
      .total_steps(total_steps));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int brev(input int v, input int n);
      int r = 0;
      for (int b = 0; b < n; b++) r = (r << 1) | ((v >> b) & 1);
      return r;
   endfunction

   task automatic check_triple(input int lo, input int hi, input int k, input bit lst,
                               input int tot, input string tag);
      chk(valid === 1'b1, {tag, " R2 valid"}, int'(valid), 1);
      chk(int'(lo_idx) == lo, {tag, " R3 R5 lo_idx"}, int'(lo_idx), lo);
      chk(int'(hi_idx) == hi, {tag, " R3 R5 hi_idx"}, int'(hi_idx), hi);
      chk(int'(coef_idx) == k, {tag, " R4 coef_idx"}, int'(coef_idx), k);
      chk(last === lst, {tag, " R9 last"}, int'(last), int'(lst));
      chk(int'(total_steps) == tot, {tag, " R8 total_steps"}, int'(total_steps), tot);
   endtask

   task automatic run(input int l, input bit rv, input bit md);
      int n = 1 << l;
      int q_lo[$], q_hi[$], q_k[$];
      int cnt;
      for (int sz = 2; sz <= n; sz *= 2) begin
         for (int g = 0; g < n; g += sz) begin
            int k = 0;
            for (int j = g; j < g + sz / 2; j++) begin
               q_lo.push_back(rv ? brev(j, l) : j);
               q_hi.push_back(rv ? brev(j + sz / 2, l) : j + sz / 2);
               q_k.push_back(k);
               k += n / sz;
            end
         end
      end
      cnt = q_lo.size();
      @(negedge clk);
      log2n = LW'(l); rev_order = rv; step_mode = md; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int e = 0; e < cnt; e++) begin
         check_triple(q_lo[e], q_hi[e], q_k[e], e == cnt - 1, cnt,
                      md ? "R7 step-mode" : "R6 free-run");
         if (md) begin
            @(negedge clk);
            check_triple(q_lo[e], q_hi[e], q_k[e], e == cnt - 1, cnt, "R7 hold");
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
         end else if (e == 1) begin
            // R10: restart attempt with another size while busy
            start = 1'b1; log2n = LW'(l == 1 ? 2 : 1);
            @(negedge clk);
            start = 1'b0; log2n = LW'(l);
         end else begin
            @(negedge clk);
         end
      end
      chk(busy === 1'b0, "R9 busy after final", int'(busy), 0);
      chk(valid === 1'b0, "R9 valid after final", int'(valid), 0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; start = 1'b0; step = 1'b0; step_mode = 1'b0;
      rev_order = 1'b0; log2n = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0, "R1 busy", int'(busy), 0);
      chk(valid === 1'b0, "R1 valid", int'(valid), 0);
      chk(last === 1'b0, "R1 last", int'(last), 0);
      chk(total_steps == '0, "R1 total_steps", int'(total_steps), 0);

      // R10: out-of-range sizes are refused
      log2n = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0, "R10 log2n=0 ignored", int'(busy), 0);
      log2n = LW'(MAXL + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0, "R10 log2n>max ignored", int'(busy), 0);

      for (int l = 1; l <= 4; l++)
         for (int rv = 0; rv < 2; rv++)
            for (int md = 0; md < 2; md++)
               run(l, rv[0], md[0]);
      run(MAXL, 1'b1, 1'b0);
      run(3, 1'b0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule